// File: doc/BRIEF.md
# Peripheral Clock Gate Register Bank

This block gates the clocks of up to 64 peripherals under software control. A small synchronous register port exposes, for each bank of 32 peripherals, a write-one-to-set enable register, a write-one-to-clear disable register and a read-only status register. Peripheral N belongs to bank N/32 and is controlled by bit N mod 32 of that bank's registers. The block keeps one enable bit per peripheral. It drives that bit out as a clock-enable, and it also drives a gated copy of the input clock for each peripheral.

Peripherals 0 and 1 are fixed on. Their enable bits are always 1 and their gated clocks always follow the input clock. Every other peripheral comes out of reset disabled. Each gated clock takes a change of enable only at a falling edge of the input clock, so turning a clock on or off never produces a clipped high pulse.

Register addresses are word addresses. Bits [1:0] select the function: 0 = set, 1 = clear, 2 = status, 3 = unused. Bit [2] selects the bank. Every address bit above bit 2 must be zero for the access to hit.

Top module: `pcg_gate_bank`

## Requirements
- R1: After reset every clock-enable is 0 except indices 0 and 1. A status read returns 32'h0000_0003 for bank 0 (address 2) and 0 for bank 1 (address 6).
- R2: A write to the set register (address 0 for bank 0, address 4 for bank 1) turns on every peripheral whose data bit is 1. The clock-enable rises at the clock edge that accepts the write.
- R3: A write to the clear register (address 1 for bank 0, address 5 for bank 1) turns off every gateable peripheral whose data bit is 1, at the clock edge that accepts the write.
- R4: A data bit of 0 in a set or clear write leaves that peripheral unchanged. Cycles without a write leave every enable unchanged.
- R5: Indices 0 and 1 ignore writes. Their clock-enables are always 1 and bits 1:0 of the bank 0 status read as 1.
- R6: A status read returns, in the cycle after the address is presented, the enable state of the addressed bank as it stood in the cycle the address was presented. Bit k of the result is the enable of peripheral 32*bank + k.
- R7: The clock-enable outputs change only at a rising clock edge that accepts a set or clear write.
- R8: A gated clock is low whenever the input clock is low. During each high phase it equals the enable that was held at the previous falling edge. An enable set during a high phase therefore produces its first pulse at the next rising edge, and a clear lets the current pulse finish in full.
- R9: A write to the status address, to function code 3, or to any address with a bit above bit 2 set changes no enable. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address: [1:0] function, [2] bank, [3] must be 0 |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data, one bit per peripheral of the bank |
| bus_rdata | output | 32 | Registered read data, one cycle after the address |
| clk_en | output | 64 | Enable state per peripheral |
| gclk | output | 64 | Gated clock per peripheral |

## Verification
A register write can coincide with the high phase of the clock it is gating. The bench sets and clears single peripherals in both banks. It samples each gated clock in the middle of the high phase right after the accepting edge, and again in the following low and high phases. A correct gate keeps the old level for the rest of that high phase and switches at the next falling edge. A second coincidence is a status read in the cycle right after a write. The random mix produces back-to-back write and read pairs, and each read is judged against a bench model that has already applied the write.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // Function selected by the low two bits of the word address.
  typedef enum logic [1:0] {
    FN_SET  = 2'd0,
    FN_CLR  = 2'd1,
    FN_STAT = 2'd2,
    FN_NONE = 2'd3
  } pcg_fn_e;

  function automatic pcg_fn_e fn_of(input logic [1:0] code);
    return pcg_fn_e'(code);
  endfunction

endpackage

// File: rtl/pcg_regdec.sv
module pcg_regdec
  import pcg_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 4,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM      = NUM_BANKS * BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BANK_W-1:0] wdata,
  output logic              hit,
  output pcg_fn_e           fn,
  output logic [BSEL_W-1:0] bank_idx,
  output logic [NUM-1:0]    set_mask,
  output logic [NUM-1:0]    clr_mask
);

  localparam int UP_LO = 2 + BSEL_W;

  logic upper_zero;
  logic bank_ok;
  logic wr_hit;

  generate
    if (ADDR_W > UP_LO) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:UP_LO] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign fn       = fn_of(addr[1:0]);
  assign bank_idx = addr[2 +: BSEL_W];
  assign bank_ok  = ({{(32-BSEL_W){1'b0}}, bank_idx} < NUM_BANKS);
  assign hit      = upper_zero && bank_ok;
  assign wr_hit   = hit && wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_hit && (bank_idx == BSEL_W'(b));
    assign set_mask[b*BANK_W +: BANK_W] = (sel && fn == FN_SET) ? wdata : '0;
    assign clr_mask[b*BANK_W +: BANK_W] = (sel && fn == FN_CLR) ? wdata : '0;
  end

endmodule

// File: rtl/pcg_state.sv
module pcg_state #(
  parameter int NUM      = 64,
  parameter int FIXED_ON = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_mask,
  input  logic [NUM-1:0] clr_mask,
  output logic [NUM-1:0] en_q
);

  function automatic logic [NUM-1:0] mk_fixed();
    logic [NUM-1:0] m;
    m = '0;
    for (int i = 0; i < NUM; i++) m[i] = (i < FIXED_ON);
    return m;
  endfunction

  localparam logic [NUM-1:0] FIXED_MASK = mk_fixed();

  // Set and clear are applied first. The fixed indices are then forced on.
  function automatic logic [NUM-1:0] next_en(input logic [NUM-1:0] cur,
                                             input logic [NUM-1:0] s,
                                             input logic [NUM-1:0] c);
    return ((cur | s) & ~c) | FIXED_MASK;
  endfunction

  logic [NUM-1:0] en_d;
  assign en_d = next_en(en_q, set_mask, clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= FIXED_MASK;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/pcg_clk_gate.sv
module pcg_clk_gate #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);

  // The enable is captured while the clock is low, so it cannot change during a high phase.
  logic en_lo;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lo <= RST_VAL;
    else        en_lo <= en;
  end

  assign gclk = clk & en_lo;

endmodule

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int FIXED_ON   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [BANK_W-1:0]     bus_wdata,
  output logic [BANK_W-1:0]     bus_rdata,
  output logic [NUM_PERIPH-1:0] clk_en,
  output logic [NUM_PERIPH-1:0] gclk
);

  localparam int NUM_BANKS = NUM_PERIPH / BANK_W;
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                  dec_hit;
  pcg_fn_e               dec_fn;
  logic [BSEL_W-1:0]     dec_bank;
  logic [NUM_PERIPH-1:0] set_mask;
  logic [NUM_PERIPH-1:0] clr_mask;
  logic [NUM_PERIPH-1:0] en_q;
  logic [BANK_W-1:0]     rd_word;

  pcg_regdec #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
  ) dec_i (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .hit(dec_hit), .fn(dec_fn), .bank_idx(dec_bank),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  pcg_state #(
    .NUM(NUM_PERIPH), .FIXED_ON(FIXED_ON)
  ) st_i (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask), .en_q(en_q)
  );

  assign clk_en = en_q;

  // Status mux: the addressed bank's slice of the enable state.
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_hit && dec_fn == FN_STAT && dec_bank == BSEL_W'(b))
        rd_word = en_q[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_word;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_gate
    pcg_clk_gate #(.RST_VAL(i < FIXED_ON)) gate_i (
      .clk(clk), .rst_n(rst_n), .en(en_q[i]), .gclk(gclk[i])
    );
  end

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int NUM_PERIPH = 64,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic [BANK_W-1:0]     bus_wdata,
  input logic [BANK_W-1:0]     bus_rdata,
  input logic [NUM_PERIPH-1:0] clk_en,
  input logic [NUM_PERIPH-1:0] gclk
);

  p_fixed_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[1:0] == 2'b11);

  p_set_b0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      ((clk_en[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_b1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(5)) |=>
      ((clk_en[2*BANK_W-1:BANK_W] & $past(bus_wdata)) == '0));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(clk_en));

  p_bad_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[ADDR_W-1:3] != '0 || bus_addr[1:0] >= 2'd2)) |=> $stable(clk_en));

  p_stat_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(2)) |=> (bus_rdata == $past(clk_en[BANK_W-1:0])));

  p_none_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(3)) |=> (bus_rdata == '0));

  // Values sampled just before a rising edge belong to the low phase.
  p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gclk == '0);

  // Values sampled just before a falling edge belong to the high phase.
  p_gate_follow_r8: assert property (@(negedge clk) disable iff (!rst_n)
    gclk == $past(clk_en));

endmodule

bind pcg_gate_bank pcg_checker #(
  .NUM_PERIPH(NUM_PERIPH), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en), .gclk(gclk)
);

// File: tb/pcg_gate_bank_tb_top.sv
`timescale 1ns/1ps
module pcg_gate_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'hF;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] clk_en;
  logic [63:0] gclk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model;

  always #10 clk = ~clk;

  pcg_gate_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en), .gclk(gclk)
  );

  // Address hits when bit 3 is 0. Bit 2 is the bank and bits [1:0] the function.
  function automatic logic [63:0] exp_write(input logic [63:0] s,
                                            input logic [3:0] a,
                                            input logic [31:0] d);
    logic [63:0] m;
    m = a[2] ? {d, 32'h0} : {32'h0, d};
    if (!a[3] && a[1:0] == 2'd0) s = s | m;
    if (!a[3] && a[1:0] == 2'd1) s = s & ~m;
    s[1:0] = 2'b11;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [63:0] s, input logic [3:0] a);
    if (a[3] || a[1:0] != 2'd2) return 32'h0;
    return a[2] ? s[63:32] : s[31:0];
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input string req, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 4'hF;
    model = exp_write(model, a, d);
    check64(req, clk_en, model);
  endtask

  task automatic do_read(input string req, input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); #1;
    bus_addr = 4'hF;
    check64(req, {32'h0, bus_rdata}, {32'h0, exp_read(model, a)});
  endtask

  // Sets and then clears one peripheral. After each write the gated clock is
  // sampled in the same high phase, the next low phase and the next high phase.
  task automatic gate_seq(input int idx);
    logic [3:0] sa, ca;
    sa = (idx >= 32) ? 4'd4 : 4'd0;
    ca = (idx >= 32) ? 4'd5 : 4'd1;
    do_write("R2", sa, 32'h1 << (idx % 32));
    #4;  check64("R8 no early pulse", {63'h0, gclk[idx]}, 64'h0);
    #10; check64("R8 low phase", {63'h0, gclk[idx]}, 64'h0);
    #10; check64("R8 pulse after set", {63'h0, gclk[idx]}, 64'h1);
    do_write("R3", ca, 32'h1 << (idx % 32));
    #4;  check64("R8 pulse not cut", {63'h0, gclk[idx]}, 64'h1);
    #10; check64("R8 low phase", {63'h0, gclk[idx]}, 64'h0);
    #10; check64("R8 gated off", {63'h0, gclk[idx]}, 64'h0);
  endtask

  initial begin : watchdog
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [3:0] addr_pool [10];
    void'($urandom(32'd2024));
    addr_pool = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd12};
    model = 64'h3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: state after reset
    #2 check64("R1 clk_en", clk_en, 64'h3);
    do_read("R1 status bank0", 4'd2);
    do_read("R1 status bank1", 4'd6);

    // R2, R4: set some bits. Zero bits leave the others alone.
    do_write("R2 set bank0", 4'd0, 32'hF0F0_0000);
    do_write("R4 zero data set", 4'd0, 32'h0);
    do_write("R2 set bank1", 4'd4, 32'h8000_0001);
    do_read("R6 status bank1", 4'd6);
    // R3: clear a subset
    do_write("R3 clear bank0", 4'd1, 32'h3030_0000);
    do_write("R4 zero data clear", 4'd5, 32'h0);
    do_read("R6 status bank0", 4'd2);
    // R5: the fixed indices ignore a clear
    do_write("R5 clear fixed", 4'd1, 32'hFFFF_FFFF);
    check64("R5 fixed bits", {62'h0, clk_en[1:0]}, 64'h3);
    do_read("R5 status fixed", 4'd2);
    // R9: undecoded writes and reads
    do_write("R9 write status addr", 4'd2, 32'h0000_FF00);
    do_write("R9 write fn3", 4'd7, 32'hFFFF_FFFF);
    do_write("R9 write upper addr", 4'd8, 32'hFFFF_FFFF);
    do_read("R9 read fn3", 4'd3);
    do_read("R9 read upper", 4'd12);

    // R7: no change across idle cycles
    @(negedge clk);
    repeat (3) @(posedge clk);
    #1 check64("R7 idle stable", clk_en, model);

    // R8: gate timing in both banks and on a fixed index
    gate_seq(5);
    gate_seq(40);
    @(posedge clk); #5;
    check64("R8 fixed follows clk", {63'h0, gclk[0]}, 64'h1);

    // Random mix of writes and reads against the model
    for (int k = 0; k < 600; k++) begin
      logic [3:0] a;
      a = addr_pool[$urandom_range(0, 9)];
      if ($urandom_range(0, 1) == 1)
        do_write("R2/R3/R4 random write", a, $urandom());
      else
        do_read("R6/R9 random read", a);
    end

    // R3: clear everything, with the fixed indices left on
    do_write("R3 clear all b0", 4'd1, 32'hFFFF_FFFF);
    do_write("R3 clear all b1", 4'd5, 32'hFFFF_FFFF);
    check64("R3 all cleared", clk_en, 64'h3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule